// File: doc/BRIEF.md
# Half-Duplex SPI Slave with Driven-Bit Readback

This block is a word-oriented SPI slave. The serial clock and chip-select come from an external master. Both are brought into the system clock domain through synchronizers, and all shifting happens on edges detected there. The system clock must run at least four times as fast as the serial clock. Timing is SPI mode 0: outgoing data changes after the serial clock falls, incoming data is sampled when it rises, and words travel MSB first. While chip-select stays low, words follow one another back to back. A new transmit word and a new format are captured at the start of every word.

Each format index carries a half-duplex enable. When the format captured for a word has half-duplex set, the slave turns the MOSI line around and drives its transmit data on it. MISO stays released, and nothing is received for that word. In both modes the slave reads back every bit it drives from the pin's input path. The compare happens on the next rising serial edge, half a serial period after the bit was launched. A mismatch sets a sticky error flag, and that flag can raise an interrupt.

Top module: `hdx_spi_slave`

## Requirements
- R1: After reset both output enables are low, `done_o` is low, `bit_err_o` is low and `rx_word_o` is zero.
- R2: In a full-duplex word, the MOSI bits sampled on the W rising serial edges form `rx_word_o` MSB first. `done_o` pulses for one cycle after the W-th rising edge.
- R3: In a full-duplex word, `tx_word_i` is captured at word start and driven MSB first on `miso_o` with `miso_oe_o` high and `mosi_oe_o` low. Word start is either chip-select assertion or completion of the previous word. The bit advances after each falling edge.
- R4: When `fmt_hdx_i[fmt_sel_i]` is 1 at word start, the captured word is driven MSB first on `mosi_o` with `mosi_oe_o` high and `miso_oe_o` low.
- R5: A half-duplex word leaves `rx_word_o` unchanged, but `done_o` still pulses when it completes.
- R6: The duplex mode is captured per word, so consecutive words inside one chip-select assertion can alternate between full and half duplex.
- R7: Once chip-select is high, both output enables are low.
- R8: If chip-select rises before W bits, the word is aborted with no `done_o` pulse. The next word starts again from the MSB.
- R9: A driven bit whose pin readback differs at the next rising serial edge sets `bit_err_o`. The flag stays set until `bit_err_clr_i`. `irq_o` equals `bit_err_o` gated by `irq_en_i`.
- R10: When a mismatch and `bit_err_clr_i` land in the same cycle, the flag ends up set.
- R11: Words whose readback matches leave `bit_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip-select, active low |
| mosi_i | input | 1 | MOSI pin input path |
| mosi_o | output | 1 | MOSI drive value (half duplex) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input path (readback) |
| miso_o | output | 1 | MISO drive value |
| miso_oe_o | output | 1 | MISO output enable |
| tx_word_i | input | W | Word to send, captured at word start |
| fmt_sel_i | input | FMT_W | Format index, captured at word start |
| fmt_hdx_i | input | NFMT | Half-duplex enable for each format |
| irq_en_i | input | 1 | Interrupt enable |
| bit_err_clr_i | input | 1 | Clears the error flag |
| rx_word_o | output | W | Last word received in full duplex |
| done_o | output | 1 | One-cycle word-complete pulse |
| bit_err_o | output | 1 | Sticky readback error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Three events can fall in the same system cycle: the readback mismatch on a word's last bit, that word's `done_o` pulse and receive-word update, and a software clear of the error flag. The bench corrupts only the LSB on the pin and holds `bit_err_clr_i` high across the three cycles that end at that bit's compare. This makes the clear fall in the same cycle as the error set. It then expects the flag to be set, the received word to still arrive through the scoreboard, and the word the master collected to differ from the transmit word in exactly the corrupted bit.

// File: rtl/hdx_spi_pkg.sv
package hdx_spi_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hdx_spi_sync_edge.sv
module hdx_spi_sync_edge #(
  parameter int unsigned STAGES = hdx_spi_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic cs_start_o
);
  logic [STAGES-1:0] sclk_pipe, cs_pipe;
  logic sclk_q, cs_act_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sclk_pipe[g] <= 1'b0;
        cs_pipe[g]   <= 1'b1;
      end else begin
        sclk_pipe[g] <= (g == 0) ? sclk_i : sclk_pipe[(g == 0) ? 0 : g-1];
        cs_pipe[g]   <= (g == 0) ? cs_ni  : cs_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      cs_act_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_pipe[STAGES-1];
      cs_act_q <= cs_act_o;
    end
  end

  assign sclk_rise_o = sclk_pipe[STAGES-1] & ~sclk_q;
  assign sclk_fall_o = ~sclk_pipe[STAGES-1] & sclk_q;
  assign cs_act_o    = ~cs_pipe[STAGES-1];
  assign cs_start_o  = cs_act_o & ~cs_act_q;
endmodule

// File: rtl/hdx_spi_shift.sv
module hdx_spi_shift #(
  parameter int unsigned W     = 8,
  parameter int unsigned NFMT  = 4,
  parameter int unsigned FMT_W = hdx_spi_pkg::idx_w(NFMT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             cs_act_i,
  input  logic             cs_start_i,
  input  logic             mosi_i,
  input  logic [W-1:0]     tx_word_i,
  input  logic [FMT_W-1:0] fmt_sel_i,
  input  logic [NFMT-1:0]  fmt_hdx_i,
  output logic             drive_bit_o,
  output logic             hdx_o,
  output logic             act_o,
  output logic             done_o,
  output logic [W-1:0]     rx_word_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     tx_sh, rx_sh;
  logic [CNT_W-1:0] cnt;
  logic             hdx_q, act_q;
  logic [W-1:0]     rx_next;

  assign rx_next = {rx_sh[W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      cnt       <= '0;
      hdx_q     <= 1'b0;
      act_q     <= 1'b0;
      done_o    <= 1'b0;
      rx_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!cs_act_i) begin
        act_q <= 1'b0;
        cnt   <= '0;
      end else if (cs_start_i) begin
        act_q <= 1'b1;
        cnt   <= '0;
        tx_sh <= tx_word_i;
        hdx_q <= fmt_hdx_i[fmt_sel_i];
      end else if (act_q) begin
        if (rise_i) begin
          if (!hdx_q) rx_sh <= rx_next;
          if (cnt == LAST) begin
            done_o <= 1'b1;
            if (!hdx_q) rx_word_o <= rx_next;
            cnt   <= '0;
            tx_sh <= tx_word_i;
            hdx_q <= fmt_hdx_i[fmt_sel_i];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (fall_i && cnt != '0) begin
          tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
      end
    end
  end

  assign drive_bit_o = tx_sh[W-1];
  assign hdx_o       = hdx_q;
  assign act_o       = act_q;

  assert_done_on_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rise_i && act_q && cnt == LAST));
  assert_hdx_keeps_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(hdx_q)) |-> $stable(rx_word_o));
  assert_abort_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !done_o);
endmodule

// File: rtl/hdx_spi_selfchk.sv
module hdx_spi_selfchk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic expect_i,
  input  logic pin_i,
  input  logic clr_i,
  output logic err_o
);
  logic mismatch;
  assign mismatch = strobe_i && (pin_i != expect_i);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (mismatch) err_o <= 1'b1;
    else if (clr_i)    err_o <= 1'b0;
  end

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && pin_i != expect_i) |=> err_o);
endmodule

// File: rtl/hdx_spi_slave.sv
module hdx_spi_slave #(
  parameter int unsigned W     = 8,
  parameter int unsigned NFMT  = 4,
  parameter int unsigned FMT_W = hdx_spi_pkg::idx_w(NFMT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic [W-1:0]     tx_word_i,
  input  logic [FMT_W-1:0] fmt_sel_i,
  input  logic [NFMT-1:0]  fmt_hdx_i,
  input  logic             irq_en_i,
  input  logic             bit_err_clr_i,
  output logic [W-1:0]     rx_word_o,
  output logic             done_o,
  output logic             bit_err_o,
  output logic             irq_o
);
  logic rise, fall, cs_act, cs_start;
  logic drive_bit, hdx, act;

  hdx_spi_sync_edge u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni,
    .sclk_rise_o(rise), .sclk_fall_o(fall),
    .cs_act_o(cs_act), .cs_start_o(cs_start)
  );

  hdx_spi_shift #(.W(W), .NFMT(NFMT), .FMT_W(FMT_W)) u_shift (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .cs_act_i(cs_act), .cs_start_i(cs_start),
    .mosi_i, .tx_word_i, .fmt_sel_i, .fmt_hdx_i,
    .drive_bit_o(drive_bit), .hdx_o(hdx), .act_o(act),
    .done_o, .rx_word_o
  );

  hdx_spi_selfchk u_chk (
    .clk_i, .rst_ni,
    .strobe_i(rise & act),
    .expect_i(drive_bit),
    .pin_i(hdx ? mosi_i : miso_i),
    .clr_i(bit_err_clr_i),
    .err_o(bit_err_o)
  );

  assign mosi_o    = drive_bit;
  assign miso_o    = drive_bit;
  assign mosi_oe_o = act & hdx;
  assign miso_oe_o = act & ~hdx;
  assign irq_o     = bit_err_o & irq_en_i;

  assert_oe_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mosi_oe_o && miso_oe_o));
  assert_cs_high_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> (!mosi_oe_o && !miso_oe_o));
endmodule

// File: tb/hdx_spi_slave_tb_top.sv
module hdx_spi_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, m_mosi = 1'b0, inj = 1'b0;
  logic [7:0] tx_word = '0;
  logic [1:0] fmt_sel = '0;
  logic [3:0] fmt_hdx = 4'b1010;
  logic irq_en = 1'b0, clr = 1'b0;
  logic mosi_o, mosi_oe, miso_o, miso_oe, done, bit_err, irq;
  logic [7:0] rx_word;
  logic mosi_pin, miso_pin;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] hold = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus model: inj flips the driven value as seen on the pin
  assign mosi_pin = mosi_oe ? (mosi_o ^ inj) : m_mosi;
  assign miso_pin = miso_oe ? (miso_o ^ inj) : 1'b1;

  hdx_spi_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi_pin), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_pin), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .tx_word_i(tx_word), .fmt_sel_i(fmt_sel), .fmt_hdx_i(fmt_hdx),
    .irq_en_i(irq_en), .bit_err_clr_i(clr),
    .rx_word_o(rx_word), .done_o(done), .bit_err_o(bit_err), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: every done pulse pops one expected receive word
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", rx_word, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R2/R5 rx_word", rx_word, e);
      end
    end
  end

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(!mosi_oe && !miso_oe, "R7 oe after cs high", {6'b0, mosi_oe, miso_oe}, 8'h00);
  endtask

  task automatic word(input logic [7:0] mdata, input bit hdx, input logic [7:0] exp_tx,
                      input int nbits, input logic [7:0] inj_m, input logic [7:0] clr_m,
                      input logic [7:0] nxt_tx, input logic [1:0] nxt_fmt);
    logic [7:0] got;
    got = '0;
    if (nbits == 8) begin
      exp_q.push_back(hdx ? hold : mdata);
      if (!hdx) hold = mdata;
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); m_mosi = mdata[7-i]; inj = inj_m[7-i];
      repeat (3) @(negedge clk);
      sclk = 1'b1; clr = clr_m[7-i];
      got[7-i] = hdx ? mosi_pin : miso_pin;
      if (i == 0) begin
        if (hdx) chk(mosi_oe && !miso_oe, "R4 hdx drives mosi", {6'b0, mosi_oe, miso_oe}, 8'h02);
        else     chk(miso_oe && !mosi_oe, "R3 full drives miso", {6'b0, mosi_oe, miso_oe}, 8'h01);
      end
      repeat (3) @(negedge clk); clr = 1'b0;
      @(negedge clk); sclk = 1'b0;
      if (i == 0) begin tx_word = nxt_tx; fmt_sel = nxt_fmt; end
    end
    @(negedge clk); inj = 1'b0;
    if (nbits == 8)
      chk(got == (exp_tx ^ inj_m), hdx ? "R4 master got word" : "R3 master got word",
          got, exp_tx ^ inj_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mosi_oe && !miso_oe && !done && !bit_err && rx_word == 0, "R1 reset",
        {mosi_oe, miso_oe, done, bit_err, 4'b0}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 full -> half -> full inside one chip-select assertion (formats 1,3 are half duplex)
    tx_word = 8'hA5; fmt_sel = 2'd0;
    cs_lo();
    word(8'h3C, 1'b0, 8'hA5, 8, 8'h00, 8'h00, 8'h5A, 2'd1);
    word(8'hFF, 1'b1, 8'h5A, 8, 8'h00, 8'h00, 8'hC3, 2'd2);
    word(8'h81, 1'b0, 8'hC3, 8, 8'h00, 8'h00, 8'h00, 2'd0);
    cs_hi();
    chk(!bit_err, "R11 no error on clean words", {7'b0, bit_err}, 8'h00);

    // R8 abort after three bits, then a fresh word from the MSB
    tx_word = 8'hF0; fmt_sel = 2'd0;
    cs_lo();
    word(8'h55, 1'b0, 8'hF0, 3, 8'h00, 8'h00, 8'h96, 2'd0);
    cs_hi();
    chk(rx_word == 8'h81, "R8 rx unchanged after abort", rx_word, 8'h81);
    cs_lo();
    word(8'hE7, 1'b0, 8'h96, 8, 8'h00, 8'h00, 8'h00, 2'd0);
    cs_hi();

    // R9 mismatch in half duplex sets flag and irq
    irq_en = 1'b1; tx_word = 8'h0F; fmt_sel = 2'd3;
    cs_lo();
    word(8'h00, 1'b1, 8'h0F, 8, 8'h10, 8'h00, 8'h00, 2'd0);
    cs_hi();
    chk(bit_err, "R9 flag set", {7'b0, bit_err}, 8'h01);
    chk(irq, "R9 irq enabled", {7'b0, irq}, 8'h01);
    repeat (20) @(negedge clk);
    chk(bit_err, "R9 flag sticky", {7'b0, bit_err}, 8'h01);
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    chk(!bit_err && !irq, "R9 clear", {6'b0, bit_err, irq}, 8'h00);

    // R10 error on last bit, same cycle as clear and done
    tx_word = 8'h6B; fmt_sel = 2'd0;
    cs_lo();
    word(8'h2D, 1'b0, 8'h6B, 8, 8'h01, 8'h01, 8'h00, 2'd0);
    cs_hi();
    chk(bit_err, "R10 set beats clear", {7'b0, bit_err}, 8'h01);
    irq_en = 1'b0; @(negedge clk);
    chk(!irq, "R9 irq masked", {7'b0, irq}, 8'h00);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all words completed", 8'(exp_q.size()), 8'h00);
    summary();
  end
endmodule